// File: doc/BRIEF.md
# Bank-Interleaved DRAM Request Scheduler

This block sits between cache controllers and a simplified DRAM command port. It accepts read and write requests, sorts each one by its bank field into a small FIFO for that bank, and issues activate, read, write and precharge commands. Each bank's open-row state and minimum-delay timers are tracked separately. This lets one bank open a row while another transfers data. As a result, requests to different banks may finish out of order. Within a bank, requests keep their arrival order.

Read data comes back from the DRAM a fixed CAS latency after the read command. The scheduler captures it and returns it with the tag the requester supplied. Writes carry their data on the command cycle and produce no response. Each cycle, the command arbiter picks one bank. A read or write to an open row beats an activate, and an activate beats a precharge. Within each class the choice rotates round-robin, starting after the last granted bank.

The request side uses valid/ready. A request transfers in a cycle where `req_valid` and `req_ready` are both high. `req_ready` depends only on whether the queue for the bank named by `req_bank` is full, so the requester may change the bank while it waits. The response side carries valid only: the DRAM cannot be stalled, so the consumer must accept a response in the cycle it is shown.

Top module: `dram_req_sched`

## Requirements
- R1: After reset, with no request pending, `req_ready` is 1, `cmd_valid` is 0 and `rsp_valid` is 0.
- R2: `cmd_op` encodes 0 = precharge, 1 = activate, 2 = read, 3 = write. An activate goes only to a bank with no open row, and at least T_RP cycles after that bank's last precharge. A read or write goes only to a bank whose row is open, and at least T_RCD cycles after that bank's activate.
- R3: Every accepted read produces exactly one response carrying its tag. The response data is the value most recently written to that bank/row/column by an earlier accepted write, or the DRAM's initial content if there was no such write.
- R4: A lone read to a bank with no open row and nothing pending gives `rsp_valid` exactly T_RCD + CAS_LAT + 2 cycles after the cycle in which it was accepted.
- R5: A write command is never issued within CAS_LAT cycles after a read command, so read data and write data never share the data lines.
- R6: Back-to-back requests to the same row of one bank are served with a single activate.
- R7: A bank whose queue has drained precharges its open row once and returns to the idle state. A precharge goes only to a bank with an open row.
- R8: A read to one bank can complete before an earlier-accepted read to another bank that needs a row change.
- R9: `req_ready` is 0 exactly when the queue of the bank named by `req_bank` holds QDEPTH requests. The queues of other banks still accept requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Queue of the addressed bank has room |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_wdata | input | DATA_W | Write data |
| req_tag | input | TAG_W | Requester tag, returned with read data |
| cmd_valid | output | 1 | A DRAM command is issued this cycle |
| cmd_op | output | 2 | Command code (see R2) |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Row for an activate |
| cmd_col | output | COL_W | Column for a read or write |
| cmd_wdata | output | DATA_W | Write data, driven with a write command |
| dram_rdata | input | DATA_W | DRAM read data, valid CAS_LAT cycles after a read |
| rsp_valid | output | 1 | Read response valid |
| rsp_tag | output | TAG_W | Tag of the returned read |
| rsp_data | output | DATA_W | Returned read data |

## Verification
The occupancy and spacing checks assume that `req_bank` is always a driven, known value. They also assume that the DRAM returns data exactly CAS_LAT cycles after every read and never stalls. The bench holds `req_bank` at a defined value throughout, and its bank responder schedules each read's data on a ring of slots that drains at a fixed offset. The response scoreboard relies on the requester never reusing a tag while a read with that tag is still outstanding. The bench therefore draws tags only from a free list, which is released when each response arrives.

// File: rtl/dsched_pkg.sv
package dsched_pkg;
  typedef enum logic [1:0] {
    OP_PRE = 2'd0,
    OP_ACT = 2'd1,
    OP_RD  = 2'd2,
    OP_WR  = 2'd3
  } dram_op_e;

  typedef enum logic [1:0] {
    BK_IDLE,
    BK_OPENING,
    BK_OPEN,
    BK_CLOSING
  } bank_state_e;
endpackage

// File: rtl/bank_queue.sv
module bank_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [PW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
  assign dout  = mem[rp[PW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[PW-1:0]] <= din;
  end
endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import dsched_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int T_RCD = 2,
  parameter int T_RP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_valid,
  input  logic [ROW_W-1:0] head_row,
  input  logic             head_write,
  input  logic             wr_block,
  input  logic             grant,
  output logic             want_act,
  output logic             want_rw,
  output logic             want_pre
);
  localparam int CMAX  = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int CNT_W = $clog2(CMAX + 1);

  bank_state_e      st;
  logic [CNT_W-1:0] cnt;
  logic [ROW_W-1:0] open_row;
  logic             can_act, can_use, hit;

  // A bank is usable in the cycle its settling timer reaches zero.
  assign can_act = (st == BK_IDLE) || (st == BK_CLOSING && cnt == '0);
  assign can_use = (st == BK_OPEN) || (st == BK_OPENING && cnt == '0);
  assign hit     = head_valid && (head_row == open_row);

  assign want_act = can_act && head_valid;
  assign want_rw  = can_use && hit && !(head_write && wr_block);
  assign want_pre = can_use && !hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= BK_IDLE;
      cnt      <= '0;
      open_row <= '0;
    end else if (grant && want_act) begin
      st       <= BK_OPENING;
      cnt      <= CNT_W'(T_RCD - 1);
      open_row <= head_row;
    end else if (grant && want_pre) begin
      st  <= BK_CLOSING;
      cnt <= CNT_W'(T_RP - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else if (st == BK_OPENING) begin
      st <= BK_OPEN;
    end else if (st == BK_CLOSING) begin
      st <= BK_IDLE;
    end
  end
endmodule

// File: rtl/cmd_arbiter.sv
module cmd_arbiter #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] want_rw,
  input  logic [N-1:0] want_act,
  input  logic [N-1:0] want_pre,
  output logic [N-1:0] grant
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] ptr;

  function automatic logic [N-1:0] rr_pick(input logic [N-1:0] req,
                                           input logic [IDX_W-1:0] p);
    logic [N-1:0] res;
    logic         found;
    int           idx;
    res   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      idx = (int'(p) + i) % N;
      if (!found && req[idx]) begin
        res[idx] = 1'b1;
        found    = 1'b1;
      end
    end
    return res;
  endfunction

  // Class priority: open-row access, then activate, then precharge.
  always_comb begin
    if (|want_rw)       grant = rr_pick(want_rw, ptr);
    else if (|want_act) grant = rr_pick(want_act, ptr);
    else                grant = rr_pick(want_pre, ptr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (grant[i]) ptr <= IDX_W'((i + 1) % N);
      end
    end
  end
endmodule

// File: rtl/dram_req_sched.sv
module dram_req_sched
  import dsched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int DATA_W    = 16,
  parameter int TAG_W     = 4,
  parameter int QDEPTH    = 4,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int CAS_LAT   = 3,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic [DATA_W-1:0] dram_rdata,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int ENT_W = 1 + ROW_W + COL_W + DATA_W + TAG_W;

  logic [NUM_BANKS-1:0] q_full, q_empty, q_push, q_pop;
  logic [NUM_BANKS-1:0] want_rw, want_act, want_pre, grant;
  logic [ENT_W-1:0]     q_head  [NUM_BANKS];
  logic                 h_write [NUM_BANKS];
  logic [ROW_W-1:0]     h_row   [NUM_BANKS];
  logic [COL_W-1:0]     h_col   [NUM_BANKS];
  logic [DATA_W-1:0]    h_wdata [NUM_BANKS];
  logic [TAG_W-1:0]     h_tag   [NUM_BANKS];
  logic [ENT_W-1:0]     req_ent;
  logic                 wr_block;
  logic                 rd_issue;
  logic [TAG_W-1:0]     rd_tag;
  dram_op_e             op;

  logic [CAS_LAT-1:0]   pv;
  logic [TAG_W-1:0]     pt [CAS_LAT];

  assign req_ent   = {req_write, req_row, req_col, req_wdata, req_tag};
  assign req_ready = !q_full[req_bank];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign q_push[b] = req_valid && req_ready && (req_bank == BANK_W'(b));
    assign q_pop[b]  = grant[b] && want_rw[b];

    bank_queue #(.W(ENT_W), .DEPTH(QDEPTH)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push[b]),
      .din   (req_ent),
      .pop   (q_pop[b]),
      .dout  (q_head[b]),
      .empty (q_empty[b]),
      .full  (q_full[b])
    );

    assign {h_write[b], h_row[b], h_col[b], h_wdata[b], h_tag[b]} = q_head[b];

    bank_ctrl #(.ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .head_valid (!q_empty[b]),
      .head_row   (h_row[b]),
      .head_write (h_write[b]),
      .wr_block   (wr_block),
      .grant      (grant[b]),
      .want_act   (want_act[b]),
      .want_rw    (want_rw[b]),
      .want_pre   (want_pre[b])
    );
  end

  cmd_arbiter #(.N(NUM_BANKS)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .want_rw  (want_rw),
    .want_act (want_act),
    .want_pre (want_pre),
    .grant    (grant)
  );

  always_comb begin
    op        = OP_PRE;
    cmd_bank  = '0;
    cmd_row   = '0;
    cmd_col   = '0;
    cmd_wdata = '0;
    rd_tag    = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (grant[b]) begin
        cmd_bank  = BANK_W'(b);
        cmd_row   = h_row[b];
        cmd_col   = h_col[b];
        cmd_wdata = h_wdata[b];
        rd_tag    = h_tag[b];
        if (want_rw[b])       op = h_write[b] ? OP_WR : OP_RD;
        else if (want_act[b]) op = OP_ACT;
        else                  op = OP_PRE;
      end
    end
  end

  assign cmd_valid = |grant;
  assign cmd_op    = op;
  assign rd_issue  = cmd_valid && (op == OP_RD);
  // Any read whose data is still on its way keeps writes off the bus.
  assign wr_block  = |pv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv        <= '0;
      rsp_valid <= 1'b0;
      rsp_tag   <= '0;
      rsp_data  <= '0;
      for (int k = 0; k < CAS_LAT; k++) pt[k] <= '0;
    end else begin
      pv[0] <= rd_issue;
      pt[0] <= rd_tag;
      for (int k = 1; k < CAS_LAT; k++) begin
        pv[k] <= pv[k-1];
        pt[k] <= pt[k-1];
      end
      rsp_valid <= pv[CAS_LAT-1];
      rsp_tag   <= pt[CAS_LAT-1];
      rsp_data  <= dram_rdata;
    end
  end
endmodule

// File: rtl/dram_req_sched_chk.sv
module dram_req_sched_chk #(
  parameter int NUM_BANKS = 4,
  parameter int QDEPTH    = 4,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int CAS_LAT   = 3,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BANK_W-1:0] req_bank,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank
);
  localparam logic [7:0] RCD8 = 8'(T_RCD);
  localparam logic [7:0] RP8  = 8'(T_RP);
  localparam logic [7:0] CL8  = 8'(CAS_LAT);
  localparam logic [7:0] QD8  = 8'(QDEPTH);

  logic [NUM_BANKS-1:0] open_q;
  logic [7:0] act_age [NUM_BANKS];
  logic [7:0] pre_age [NUM_BANKS];
  logic [7:0] occ     [NUM_BANKS];
  logic [7:0] rd_age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= '0;
      rd_age <= 8'hFF;
      for (int b = 0; b < NUM_BANKS; b++) begin
        act_age[b] <= 8'h00;
        pre_age[b] <= 8'hFF;
        occ[b]     <= 8'h00;
      end
    end else begin
      if (cmd_valid && cmd_op == 2'd2) rd_age <= 8'd1;
      else if (rd_age != 8'hFF)        rd_age <= rd_age + 8'd1;
      for (int b = 0; b < NUM_BANKS; b++) begin
        occ[b] <= occ[b]
                + 8'(req_valid && req_ready && req_bank == BANK_W'(b))
                - 8'(cmd_valid && cmd_op[1] && cmd_bank == BANK_W'(b));
        if (cmd_valid && cmd_bank == BANK_W'(b) && cmd_op == 2'd1) begin
          open_q[b]  <= 1'b1;
          act_age[b] <= 8'd1;
        end else if (act_age[b] != 8'hFF) begin
          act_age[b] <= act_age[b] + 8'd1;
        end
        if (cmd_valid && cmd_bank == BANK_W'(b) && cmd_op == 2'd0) begin
          open_q[b]  <= 1'b0;
          pre_age[b] <= 8'd1;
        end else if (pre_age[b] != 8'hFF) begin
          pre_age[b] <= pre_age[b] + 8'd1;
        end
      end
    end
  end

  // R2
  act_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1) |-> (!open_q[cmd_bank] && pre_age[cmd_bank] >= RP8));

  // R2
  rw_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op[1]) |-> (open_q[cmd_bank] && act_age[cmd_bank] >= RCD8));

  // R5
  wr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3) |-> (rd_age > CL8));

  // R7
  pre_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0) |-> open_q[cmd_bank]);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (occ[req_bank] < QD8));

  // R9
  ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (occ[req_bank] == QD8));
endmodule

bind dram_req_sched dram_req_sched_chk #(
  .NUM_BANKS (NUM_BANKS),
  .QDEPTH    (QDEPTH),
  .T_RCD     (T_RCD),
  .T_RP      (T_RP),
  .CAS_LAT   (CAS_LAT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_bank  (req_bank),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_bank  (cmd_bank)
);

// File: tb/tb_dram_req_sched.sv
module tb_dram_req_sched;
  localparam int NB = 4, RW = 3, CW = 3, DW = 16, TW = 4, QD = 4;
  localparam int RCD = 2, RP = 2, CL = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic [CW-1:0] req_col = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [TW-1:0] req_tag = '0;
  logic req_ready, cmd_valid, rsp_valid;
  logic [1:0] cmd_op, cmd_bank;
  logic [RW-1:0] cmd_row;
  logic [CW-1:0] cmd_col;
  logic [DW-1:0] cmd_wdata, rsp_data, dram_rdata = '0;
  logic [TW-1:0] rsp_tag;

  dram_req_sched #(.NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .DATA_W(DW), .TAG_W(TW),
    .QDEPTH(QD), .T_RCD(RCD), .T_RP(RP), .CAS_LAT(CL)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .req_tag(req_tag), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_wdata(cmd_wdata),
    .dram_rdata(dram_rdata), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, seq = 0, rsp_total = 0, rd_issued = 0;
  int viol_r2 = 0, viol_r5 = 0, viol_r7 = 0, wr_cmds = 0, last_rd = -100;
  int stalls = 0, other_ok = 0, acc = 0;
  bit done = 0, probe = 0;
  bit pend [16];
  logic [DW-1:0] exp_d [16];
  int rsp_seq [16], rsp_cyc [16];
  logic [DW-1:0] shadow [256], dmem [256], slot [8];
  bit open_b [NB];
  int open_row [NB], t_act [NB], t_pre [NB], act_cnt [NB], pre_cnt [NB];

  function automatic int aidx(int b, int r, int c);
    return b * 64 + r * 8 + c;
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, expv);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Behavioural DRAM responder, protocol monitor and response scoreboard
  always @(negedge clk) begin
    dram_rdata = slot[cyc % 8];
    if (rst_n && cmd_valid) begin
      int b;
      b = int'(cmd_bank);
      case (cmd_op)
        2'd1: begin
          if (open_b[b] || cyc - t_pre[b] < RP) viol_r2++;
          open_b[b] = 1; open_row[b] = int'(cmd_row); t_act[b] = cyc; act_cnt[b]++;
        end
        2'd0: begin
          if (!open_b[b]) viol_r7++;
          open_b[b] = 0; t_pre[b] = cyc; pre_cnt[b]++;
        end
        2'd2: begin
          if (!open_b[b] || cyc - t_act[b] < RCD) viol_r2++;
          slot[(cyc + CL) % 8] = dmem[aidx(b, open_row[b], int'(cmd_col))];
          last_rd = cyc;
        end
        default: begin
          if (!open_b[b] || cyc - t_act[b] < RCD) viol_r2++;
          if (cyc - last_rd <= CL) viol_r5++;
          dmem[aidx(b, open_row[b], int'(cmd_col))] = cmd_wdata;
          wr_cmds++;
        end
      endcase
    end
    if (rst_n && rsp_valid) begin
      chk(pend[rsp_tag] && rsp_data == exp_d[rsp_tag], "R3 response data/tag",
          int'(rsp_data), int'(exp_d[rsp_tag]));
      pend[rsp_tag] = 0;
      rsp_seq[rsp_tag] = seq++;
      rsp_cyc[rsp_tag] = cyc;
      rsp_total++;
    end
  end

  function automatic bit any_pend();
    for (int t = 0; t < 16; t++) if (pend[t]) return 1;
    return 0;
  endfunction

  task automatic get_tag(output int t);
    t = -1;
    while (t < 0) begin
      for (int i = 0; i < 16; i++) if (t < 0 && !pend[i]) t = i;
      if (t < 0) @(negedge clk);
    end
  endtask

  // Called at a negedge; returns at the next negedge after the transfer.
  task automatic push(input bit wr, input int b, input int r, input int c,
                      input int d, input int t);
    bit first;
    first = 1;
    req_valid = 1; req_write = wr; req_bank = 2'(b); req_row = RW'(r);
    req_col = CW'(c); req_wdata = DW'(d); req_tag = TW'(t);
    #1;
    while (!req_ready) begin
      if (first) begin
        stalls++;
        if (probe) begin
          req_bank = 2'(b ^ 1); #1;
          if (req_ready) other_ok++;
          req_bank = 2'(b); #1;
        end
        first = 0;
      end
      @(negedge clk); #1;
    end
    acc = cyc;
    if (wr) shadow[aidx(b, r, c)] = DW'(d);
    else begin
      pend[t] = 1; exp_d[t] = shadow[aidx(b, r, c)]; rd_issued++;
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic rd(input int b, input int r, input int c, output int t);
    get_tag(t);
    push(0, b, r, c, 0, t);
  endtask

  task automatic wait_idle();
    int g;
    g = 0;
    while (any_pend() && g < 2000) begin @(negedge clk); g++; end
    repeat (12) @(negedge clk);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin
      shadow[a] = DW'(a * 613 + 4660);
      dmem[a] = shadow[a];
    end
    for (int i = 0; i < 8; i++) slot[i] = '0;
    for (int b = 0; b < NB; b++) begin
      open_b[b] = 0; t_pre[b] = -100; t_act[b] = -100; act_cnt[b] = 0; pre_cnt[b] = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int ta, tb, tc, a0, p0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    // R1: reset state
    chk(req_ready == 1, "R1 req_ready", int'(req_ready), 1);
    chk(cmd_valid == 0, "R1 cmd_valid", int'(cmd_valid), 0);
    chk(rsp_valid == 0, "R1 rsp_valid", int'(rsp_valid), 0);
    @(negedge clk);

    // R4: isolated read latency
    rd(2, 3, 4, ta);
    a0 = acc;
    wait_idle();
    chk(rsp_cyc[ta] - a0 == RCD + CL + 2, "R4 latency", rsp_cyc[ta] - a0, RCD + CL + 2);

    // R6 / R7: same-row pair, then drain precharge
    a0 = act_cnt[3]; p0 = pre_cnt[3];
    rd(3, 5, 1, ta);
    rd(3, 5, 2, tb);
    wait_idle();
    chk(act_cnt[3] - a0 == 1, "R6 single activate", act_cnt[3] - a0, 1);
    chk(pre_cnt[3] - p0 == 1, "R7 one precharge", pre_cnt[3] - p0, 1);
    chk(open_b[3] == 0, "R7 bank idle", int'(open_b[3]), 0);

    // R8: cross-bank overtaking
    rd(0, 1, 0, ta);
    rd(0, 2, 0, tb);
    rd(1, 3, 0, tc);
    wait_idle();
    chk(rsp_seq[tc] < rsp_seq[tb], "R8 out of order", rsp_seq[tc], rsp_seq[tb]);

    // R9: per-bank back-pressure
    stalls = 0; other_ok = 0; probe = 1;
    for (int i = 0; i < 7; i++) rd(0, i % 2, i, ta);
    probe = 0;
    wait_idle();
    chk(stalls > 0, "R9 ready dropped on full bank", stalls, 1);
    chk(other_ok == stalls, "R9 other bank still ready", other_ok, stalls);

    // R3: sweep writes then reads, banks interleaved
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c += 5)
        for (int b = 0; b < NB; b++)
          push(1, b, r, c, 16'hA000 + aidx(b, r, c) * 3, 0);
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 4; c++)
        for (int b = 0; b < NB; b++) rd(b, r, c, ta);
    // R5: read/write mixing to stress bus turnaround
    for (int i = 0; i < 48; i++) begin
      push(1, i % 4, (i * 3) % 8, i % 8, 16'h5000 + i, 0);
      rd(i % 4, (i * 3) % 8, i % 8, ta);
      rd((i + 1) % 4, (i * 5) % 8, (i + 2) % 8, ta);
    end
    wait_idle();
    chk(!any_pend(), "R3 all reads answered", int'(any_pend()), 0);
    chk(rsp_total == rd_issued, "R3 response count", rsp_total, rd_issued);
    chk(viol_r2 == 0, "R2 bank timing/state", viol_r2, 0);
    chk(viol_r7 == 0, "R7 precharge to open bank", viol_r7, 0);
    chk(viol_r5 == 0, "R5 write after read spacing", viol_r5, 0);
    chk(wr_cmds == 64 + 48, "R5 writes issued", wr_cmds, 64 + 48);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule